// File: doc/BRIEF.md
# Queued DMA Command Tag Tracker

This block sits on the device side of a serial storage link. It keeps track of up to 32 commands that the host has queued for first-party DMA. Each queued read or write arrives on a command port with its count byte, and the tag is taken from bits 7:3 of that byte. The block answers each command with a register response. It records accepted tags in an outstanding bitmap, and a command whose tag is already outstanding is refused with an abort code.

A four-state controller (IDLE, SETUP, XFER, REPORT) serves the queue one command at a time. In IDLE it looks at the tags that are outstanding but not yet finished. If any exist, it takes the lowest-numbered one and moves to SETUP (transition "pick"). In SETUP it presents the DMA Setup descriptor: the buffer identifier carries the tag, plus the direction, the auto-activate flag and the byte count. The descriptor is held until the consumer takes it, and then the controller moves to XFER ("grant"). In XFER it subtracts the byte counts reported on the data-progress port. When the count is used up it marks the tag finished and returns to IDLE ("exhaust").

When nothing is left to serve and at least one tag has finished, IDLE moves to REPORT ("gather"). REPORT presents a Set Device Bits descriptor that holds every finished tag at once. When that descriptor is taken ("retire"), the reported tags leave both the finished bitmap and the outstanding bitmap in the same cycle, and the controller returns to IDLE.

Top module: `ncq_tag_tracker`

## Requirements
- R1: After reset the outstanding bitmap is zero and resp_valid, setup_valid and sdb_valid are all low.
- R2: A command whose tag (cmd_count bits 7:3) is not outstanding is accepted. One cycle later resp_valid is high with resp_status 0x50, resp_error 0x00 and resp_irq 0, and the tag's bit is set in active_map.
- R3: A command whose tag is already outstanding is refused. One cycle later resp_valid is high with resp_status 0x51, resp_error 0x04 and resp_irq 0, and active_map is unchanged.
- R4: When several tags are outstanding and unserved, the next descriptor is issued for the lowest tag number.
- R5: The DMA Setup descriptor has the tag in setup_buf_id bits 4:0, with all other bits zero. It has setup_dir 1 for a read and 0 for a write, and setup_count equal to the command's byte count. All fields stay stable while setup_valid is high and setup_ready is low.
- R6: setup_auto_act is 1 for writes and 0 for reads (WR_AUTO_ACT=1).
- R7: A command stays in transfer until the dat_bytes summed over dat_valid cycles reach its byte count. A final step that exceeds the remainder also completes it, and a zero byte count completes with no data. No new descriptor appears before completion.
- R8: The Set Device Bits descriptor is raised only when no outstanding tag is left unserved. sdb_done has bit n set for each finished tag n, and sdb_irq is 1. The descriptor stays stable until sdb_ready.
- R9: In the cycle sdb_valid and sdb_ready are both high, the reported tags are cleared from both the outstanding and finished bitmaps. A retired tag may then be accepted again.
- R10: Several tags can be retired by a single Set Device Bits descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Queued command present this cycle |
| cmd_count | input | 8 | Count byte; bits 7:3 carry the tag |
| cmd_write | input | 1 | 1 for a queued write, 0 for a queued read |
| cmd_bytes | input | CNT_W | Transfer length in bytes |
| resp_valid | output | 1 | Register response for the previous cycle's command |
| resp_status | output | 8 | 0x50 accepted, 0x51 refused |
| resp_error | output | 8 | 0x00 accepted, 0x04 abort |
| resp_irq | output | 1 | Interrupt flag of the response (0) |
| setup_valid | output | 1 | DMA Setup descriptor present |
| setup_ready | input | 1 | Consumer takes the DMA Setup descriptor |
| setup_buf_id | output | 32 | Buffer identifier, tag in bits 4:0 |
| setup_dir | output | 1 | 1 device-to-host (read), 0 host-to-device |
| setup_auto_act | output | 1 | Host may send write data with no activate frame |
| setup_count | output | CNT_W | Transfer count in bytes |
| dat_valid | input | 1 | Data progress step present |
| dat_bytes | input | STEP_W | Bytes moved in this step |
| sdb_valid | output | 1 | Set Device Bits descriptor present |
| sdb_ready | input | 1 | Consumer takes the Set Device Bits descriptor |
| sdb_done | output | 2**TAG_W | Bitmap of finished tags |
| sdb_irq | output | 1 | Interrupt flag of the descriptor |
| active_map | output | 2**TAG_W | Outstanding tag bitmap |

## Verification
The hardest situation to reach is one where the lowest-tag choice is actually different from arrival order. Without it, the priority encoder cannot be told apart from a first-in queue. The stimulus first queues the highest tag and holds setup_ready low, which parks the controller in SETUP. It then fills the other 31 tags in descending order and sweeps duplicates over all 32 tags. Once the first transfer is released, the bench expects the descriptors in ascending order. The batched report is reached only after every tag has finished, so a single descriptor must retire all 32.

// File: rtl/ncq_pkg.sv
package ncq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_REPORT
    } trk_state_e;

    localparam logic [7:0] STAT_GOOD  = 8'h50;
    localparam logic [7:0] STAT_FAULT = 8'h51;
    localparam logic [7:0] ERR_NONE   = 8'h00;
    localparam logic [7:0] ERR_ABORT  = 8'h04;
    localparam int         TAG_LSB    = 3;
endpackage

// File: rtl/ncq_tag_table.sv
module ncq_tag_table #(
    parameter int TAG_W = 5,
    parameter int CNT_W = 16,
    localparam int NT   = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic [TAG_W-1:0] acc_tag,
    input  logic             acc_wr,
    input  logic [CNT_W-1:0] acc_bytes,
    input  logic             fin_set,
    input  logic [TAG_W-1:0] fin_tag,
    input  logic             retire,
    input  logic [NT-1:0]    retire_mask,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_wr,
    output logic [CNT_W-1:0] rd_bytes,
    output logic [NT-1:0]    outst,
    output logic [NT-1:0]    fin_map,
    output logic             ans_valid,
    output logic             ans_abort
);
    logic [NT-1:0]    outst_q, fin_q, wr_q;
    logic [CNT_W-1:0] bytes_q [NT];
    logic             dup, take;
    logic [NT-1:0]    clr_mask;

    assign dup      = outst_q[acc_tag];
    assign take     = acc_req & ~dup;
    assign clr_mask = retire ? retire_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q   <= '0;
            fin_q     <= '0;
            wr_q      <= '0;
            ans_valid <= 1'b0;
            ans_abort <= 1'b0;
            for (int i = 0; i < NT; i++) bytes_q[i] <= '0;
        end else begin
            ans_valid <= acc_req;
            ans_abort <= acc_req & dup;
            outst_q   <= (outst_q & ~clr_mask) | (take ? (NT'(1) << acc_tag) : '0);
            fin_q     <= (fin_q & ~clr_mask) | (fin_set ? (NT'(1) << fin_tag) : '0);
            if (take) begin
                wr_q[acc_tag]    <= acc_wr;
                bytes_q[acc_tag] <= acc_bytes;
            end
        end
    end

    assign outst    = outst_q;
    assign fin_map  = fin_q;
    assign rd_wr    = wr_q[rd_tag];
    assign rd_bytes = bytes_q[rd_tag];

    AST_FIN_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_q & ~outst_q) == '0); // R9
    AST_DUP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && outst_q[acc_tag] |=> ans_valid && ans_abort); // R3
    AST_DUP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && outst_q[acc_tag] && !retire |=> outst_q == $past(outst_q)); // R3
endmodule

// File: rtl/ncq_prio_pick.sv
module ncq_prio_pick #(
    parameter int TAG_W = 5,
    localparam int NT   = 1 << TAG_W
) (
    input  logic [NT-1:0]    req,
    output logic             any,
    output logic [TAG_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            if (req[i]) idx = TAG_W'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/ncq_xfer_ctr.sv
module ncq_xfer_ctr #(
    parameter int CNT_W  = 16,
    parameter int STEP_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              step,
    input  logic [STEP_W-1:0] step_bytes,
    output logic              last
);
    localparam int W = (CNT_W > STEP_W) ? CNT_W : STEP_W;
    logic [CNT_W-1:0] rem_q;
    logic             covers;

    assign covers = W'(step_bytes) >= W'(rem_q);
    assign last   = (rem_q == '0) | (step & covers);

    always_ff @(posedge clk) begin
        if (!rst_n)       rem_q <= '0;
        else if (load)    rem_q <= load_val;
        else if (step)    rem_q <= covers ? '0 : rem_q - CNT_W'(step_bytes);
    end

    AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && !last && step_bytes != '0 |=> rem_q < $past(rem_q)); // R7
endmodule

// File: rtl/ncq_tag_tracker.sv
module ncq_tag_tracker
    import ncq_pkg::*;
#(
    parameter int TAG_W       = 5,
    parameter int CNT_W       = 16,
    parameter int STEP_W      = 14,
    parameter bit WR_AUTO_ACT = 1'b1,
    localparam int NT         = 1 << TAG_W,
    localparam int BUF_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_count,
    input  logic              cmd_write,
    input  logic [CNT_W-1:0]  cmd_bytes,
    output logic              resp_valid,
    output logic [7:0]        resp_status,
    output logic [7:0]        resp_error,
    output logic              resp_irq,
    output logic              setup_valid,
    input  logic              setup_ready,
    output logic [BUF_W-1:0]  setup_buf_id,
    output logic              setup_dir,
    output logic              setup_auto_act,
    output logic [CNT_W-1:0]  setup_count,
    input  logic              dat_valid,
    input  logic [STEP_W-1:0] dat_bytes,
    output logic              sdb_valid,
    input  logic              sdb_ready,
    output logic [NT-1:0]     sdb_done,
    output logic              sdb_irq,
    output logic [NT-1:0]     active_map
);
    trk_state_e       state_q, state_d;
    logic [TAG_W-1:0] sel_q, pick_idx;
    logic [NT-1:0]    outst, fin_map, pend;
    logic             pick_any, rd_wr, ans_valid, ans_abort, last;
    logic [CNT_W-1:0] rd_bytes;
    logic             grant, exhaust, retire;

    assign pend    = outst & ~fin_map;
    assign grant   = (state_q == ST_SETUP)  && setup_ready;
    assign exhaust = (state_q == ST_XFER)   && last;
    assign retire  = (state_q == ST_REPORT) && sdb_ready;

    ncq_tag_table #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_table (
        .clk, .rst_n,
        .acc_req(cmd_valid), .acc_tag(cmd_count[TAG_LSB +: TAG_W]),
        .acc_wr(cmd_write), .acc_bytes(cmd_bytes),
        .fin_set(exhaust), .fin_tag(sel_q),
        .retire(retire), .retire_mask(fin_map),
        .rd_tag(sel_q), .rd_wr(rd_wr), .rd_bytes(rd_bytes),
        .outst(outst), .fin_map(fin_map),
        .ans_valid(ans_valid), .ans_abort(ans_abort)
    );

    ncq_prio_pick #(.TAG_W(TAG_W)) u_pick (
        .req(pend), .any(pick_any), .idx(pick_idx)
    );

    ncq_xfer_ctr #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_ctr (
        .clk, .rst_n,
        .load(grant), .load_val(rd_bytes),
        .step(dat_valid && state_q == ST_XFER), .step_bytes(dat_bytes),
        .last(last)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_any)           state_d = ST_SETUP;   // pick
                else if (fin_map != '0) state_d = ST_REPORT;  // gather
            end
            ST_SETUP:  if (grant)   state_d = ST_XFER;        // grant
            ST_XFER:   if (exhaust) state_d = ST_IDLE;        // exhaust
            ST_REPORT: if (retire)  state_d = ST_IDLE;        // retire
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && pick_any) sel_q <= pick_idx;
        end
    end

    // outputs
    always_comb begin
        setup_valid  = (state_q == ST_SETUP);
        setup_buf_id = BUF_W'(sel_q);
        setup_dir    = ~rd_wr;
        setup_count  = rd_bytes;
        sdb_valid    = (state_q == ST_REPORT);
        sdb_done     = fin_map;
        sdb_irq      = (state_q == ST_REPORT);
        resp_valid   = ans_valid;
        resp_status  = ans_abort ? STAT_FAULT : STAT_GOOD;
        resp_error   = ans_abort ? ERR_ABORT  : ERR_NONE;
        resp_irq     = 1'b0;
        active_map   = outst;
    end

    generate
        if (WR_AUTO_ACT) begin : g_auto
            assign setup_auto_act = rd_wr;
        end else begin : g_manual
            assign setup_auto_act = 1'b0;
        end
    endgenerate

    logic [NT-1:0] below_sel;
    assign below_sel = (NT'(1) << sel_q) - NT'(1);

    AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid && !setup_ready |=> setup_valid && $stable(setup_buf_id) && $stable(setup_count)); // R5
    AST_SETUP_OUTST: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |-> active_map[setup_buf_id[TAG_W-1:0]]); // R5
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && pend != '0 |=> setup_valid && (($past(pend) & below_sel) == '0)); // R4
    AST_REPORT_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdb_valid) |-> $past(pend) == '0); // R8
    AST_RETIRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sdb_valid && sdb_ready |=> (active_map & $past(sdb_done)) == '0 && !sdb_valid); // R9
endmodule

// File: tb/sim_ncq_tag_tracker.sv
`timescale 1ns/1ps
module sim_ncq_tag_tracker;
    localparam int TAG_W = 5, CNT_W = 16, STEP_W = 14, NT = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, cmd_write = 0, setup_ready = 0, dat_valid = 0, sdb_ready = 0;
    logic [7:0] cmd_count = 0;
    logic [CNT_W-1:0] cmd_bytes = 0;
    logic [STEP_W-1:0] dat_bytes = 0;
    logic resp_valid, resp_irq, setup_valid, setup_dir, setup_auto_act, sdb_valid, sdb_irq;
    logic [7:0] resp_status, resp_error;
    logic [31:0] setup_buf_id;
    logic [CNT_W-1:0] setup_count;
    logic [NT-1:0] sdb_done, active_map;

    int n_chk = 0, n_bad = 0;
    logic [NT-1:0] model_map;

    always #2.5 clk = ~clk;

    ncq_tag_tracker u0 (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bytes_of(input int t);
        return (t + 1) * 4;
    endfunction

    task automatic send_cmd(input int tag, input bit dup);
        @(negedge clk);
        cmd_valid = 1; cmd_count = {5'(tag), 3'b101};
        cmd_write = tag[0]; cmd_bytes = CNT_W'(bytes_of(tag));
        @(negedge clk);
        cmd_valid = 0;
        chk(resp_valid == 1, dup ? "R3 valid" : "R2 valid", resp_valid, 1);
        chk(resp_status == (dup ? 8'h51 : 8'h50), dup ? "R3 status" : "R2 status", resp_status, dup ? 8'h51 : 8'h50);
        chk(resp_error == (dup ? 8'h04 : 8'h00), dup ? "R3 error" : "R2 error", resp_error, dup ? 4 : 0);
        chk(resp_irq == 0, "R2 irq", resp_irq, 0);
        if (!dup) model_map[tag] = 1'b1;
        chk(active_map == model_map, dup ? "R3 map unchanged" : "R2 map", active_map, model_map);
    endtask

    task automatic wait_setup();
        for (int k = 0; k < 40 && !setup_valid; k++) begin
            chk(sdb_valid == 0, "R8 no early report", sdb_valid, 0);
            @(negedge clk);
        end
    endtask

    task automatic serve(input int tag, input int nbytes, input bit overshoot);
        wait_setup();
        chk(setup_valid == 1, "R4 setup present", setup_valid, 1);
        chk(setup_buf_id == 32'(tag), "R4 R5 buffer id", setup_buf_id, tag);
        chk(setup_dir == !tag[0], "R5 direction", setup_dir, !tag[0]);
        chk(setup_auto_act == tag[0], "R6 auto activate", setup_auto_act, tag[0]);
        chk(setup_count == CNT_W'(nbytes), "R5 count", setup_count, nbytes);
        setup_ready = 1;
        @(negedge clk);
        setup_ready = 0;
        if (overshoot) begin
            dat_valid = 1; dat_bytes = STEP_W'(nbytes + 100);
            @(negedge clk);
            dat_valid = 0;
        end else if (nbytes > 0) begin
            for (int c = 0; c < nbytes / 4; c++) begin
                dat_valid = 1; dat_bytes = 4;
                @(negedge clk);
                dat_valid = 0;
                if (c < nbytes / 4 - 1)
                    chk(setup_valid == 0 && sdb_valid == 0, "R7 still transferring", setup_valid, 0);
            end
        end else begin
            @(negedge clk);
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_map = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(active_map == 0, "R1 map", active_map, 0);
        chk(!resp_valid && !setup_valid && !sdb_valid, "R1 valids", {resp_valid, setup_valid, sdb_valid}, 0);

        // highest tag first, parks controller in SETUP
        send_cmd(31, 0);
        for (int t = 30; t >= 0; t--) send_cmd(t, 0);
        // duplicate sweep over all tags (R3)
        for (int t = 0; t < NT; t++) send_cmd(t, 1);

        // service: 31 then ascending (R4), tag 7 overshoots (R7)
        serve(31, bytes_of(31), 0);
        for (int t = 0; t < 31; t++) serve(t, bytes_of(t), t == 7);

        // batched report (R8, R10)
        for (int k = 0; k < 10 && !sdb_valid; k++) @(negedge clk);
        chk(sdb_valid == 1, "R8 report raised", sdb_valid, 1);
        chk(sdb_done == '1, "R10 all tags in one report", sdb_done, 32'hffffffff);
        chk(sdb_irq == 1, "R8 irq", sdb_irq, 1);
        @(negedge clk);
        chk(sdb_valid == 1 && sdb_done == '1, "R8 held without ready", sdb_done, 32'hffffffff);
        sdb_ready = 1;
        @(negedge clk);
        sdb_ready = 0;
        model_map = '0;
        chk(active_map == 0, "R9 outstanding cleared", active_map, 0);
        chk(sdb_valid == 0, "R9 report dropped", sdb_valid, 0);

        // re-use of a retired tag with zero length (R9, R7)
        send_cmd(3, 0);
        wait_setup();
        chk(setup_buf_id == 32'd3, "R9 reused tag", setup_buf_id, 3);
        setup_ready = 1;
        @(negedge clk);
        setup_ready = 0;
        // zero-byte command would be expected only if sent as zero; this one carries 16 bytes
        dat_valid = 1; dat_bytes = 16;
        @(negedge clk);
        dat_valid = 0;
        for (int k = 0; k < 10 && !sdb_valid; k++) @(negedge clk);
        chk(sdb_done == 32'h8, "R8 single report", sdb_done, 8);
        sdb_ready = 1;
        @(negedge clk);
        sdb_ready = 0;

        // zero byte count completes without data (R7)
        @(negedge clk);
        cmd_valid = 1; cmd_count = {5'd9, 3'b000}; cmd_write = 0; cmd_bytes = 0;
        @(negedge clk);
        cmd_valid = 0;
        wait_setup();
        chk(setup_count == 0, "R7 zero count descriptor", setup_count, 0);
        setup_ready = 1;
        @(negedge clk);
        setup_ready = 0;
        for (int k = 0; k < 10 && !sdb_valid; k++) @(negedge clk);
        chk(sdb_valid == 1 && sdb_done == 32'h200, "R7 zero count completes", sdb_done, 32'h200);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule